// File: doc/BRIEF.md
# Pairwise Trigger Combiner and Demultiplexer

This block combines per-pair threshold results into a compact trigger word. Six track buses give fifteen unordered pairs. For every pair, an upstream lookup delivers an 8-bit momentum result and an 8-bit angle result. A trigger bit is set only when one pair meets both its momentum and its angle condition for that bit. Each cycle, the block ORs that per-pair coincidence across all pairs and presents it as a registered, active-low 8-bit summary.

Each event spans two lookup phases of a slow phase signal, which the fast system clock samples. The block demultiplexes the summary into two active-high 8-bit groups. Each group is latched at the end of its phase. Group A carries the seven low trigger bits of the high phase and the more-than-six-tracks overflow flag in its top bit. Group B carries all eight bits of the low phase. A one-cycle strobe marks each completed event.

Top module: `trig_pair_summary`

## Requirements
- R1: Pair p (index order AB=0, AC, AD, AE, AF, BC, BD, BE, BF, CD, CE, CF, DE, DF, EF=14) uses bits p*8+7..p*8 of the momentum and angle inputs. It contributes to trigger bit b only when both of its bit b inputs are high.
- R2: One clock after the inputs are applied, summary bit b is low when at least one pair contributes to bit b, and high otherwise.
- R3: When the sampled phase signal goes from high to low, group A bits 6:0 take the inverted summary from the last high-phase cycle. The group is visible two clocks after the phase input falls.
- R4: At that same update, group A bit 7 takes the overflow flag from the last high-phase cycle, and the bit 7 trigger of that phase is discarded.
- R5: When the sampled phase signal goes from low to high, all 8 bits of group B take the inverted summary from the last low-phase cycle. The group is visible two clocks after the phase input rises.
- R6: The event strobe is high for exactly one cycle, in the cycle group B updates, and only if group A has updated since the previous strobe.
- R7: After a synchronous reset, the summary is all ones, both groups are zero and the strobe is low.
- R8: Each group keeps its value in every cycle other than its own update cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_in | input | 1 | Slow lookup-phase signal; high is the first phase of an event |
| ovf_in | input | 1 | More-than-six-tracks flag, valid in the high phase |
| mom_res | input | 120 | Momentum results, 8 bits per pair, pair 0 in the low byte |
| ang_res | input | 120 | Angle results, 8 bits per pair, same layout |
| sum_n | output | 8 | Registered active-low trigger summary |
| grp_a | output | 8 | High-phase triggers 6:0 with the overflow flag in bit 7 |
| grp_b | output | 8 | Low-phase triggers 7:0 |
| evt_valid | output | 1 | One-cycle strobe when an event's group B lands |

## Verification
The summary is due one clock after its inputs. Each group is due two clocks after the phase edge that ends its phase: one register samples the phase and a second detects the edge. The strobe shares its cycle with group B and must be low again one clock later. The bench drives every input at the falling edge. It holds each phase for four clocks and samples each result at the falling edge after the rising edge on which it is due. It checks the held groups again just before the next phase edge.

// File: rtl/trig_pair_pkg.sv
package trig_pair_pkg;
  localparam int unsigned BUS_COUNT_DEF = 6;
  localparam int unsigned TRIG_BITS_DEF = 8;

  function automatic int unsigned pair_count(input int unsigned buses);
    return buses * (buses - 1) / 2;
  endfunction
endpackage

// File: rtl/pair_combine.sv
module pair_combine #(
  parameter int unsigned NPAIR = 15,
  parameter int unsigned NBIT  = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   phase_in,
  input  logic                   ovf_in,
  input  logic [NPAIR*NBIT-1:0]  mom_res,
  input  logic [NPAIR*NBIT-1:0]  ang_res,
  output logic [NBIT-1:0]        sum_n,
  output logic                   ph_q,
  output logic                   ovf_q
);
  logic [NBIT-1:0] pair_hit [NPAIR];
  logic [NBIT-1:0] any_hit;

  // per-pair coincidence of momentum and angle thresholds
  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assign pair_hit[p] = mom_res[p*NBIT +: NBIT] & ang_res[p*NBIT +: NBIT];
  end

  always_comb begin
    any_hit = '0;
    for (int p = 0; p < NPAIR; p++) any_hit = any_hit | pair_hit[p];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_n <= '1;
      ph_q  <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      sum_n <= ~any_hit;
      ph_q  <= phase_in;
      ovf_q <= ovf_in;
    end
  end

  // R2: with no coincidence anywhere in the previous cycle, nothing is flagged
  a_r2_quiet_summary: assert property (@(posedge clk) disable iff (rst)
    ((mom_res & ang_res) == '0) |=> (sum_n == '1));
  // R1: a single pair meeting both conditions on bit 0 pulls that bit low
  a_r1_pair_coincidence: assert property (@(posedge clk) disable iff (rst)
    (mom_res[0] && ang_res[0]) |=> !sum_n[0]);
endmodule

// File: rtl/phase_demux.sv
module phase_demux #(
  parameter int unsigned NBIT    = 8,
  parameter int unsigned OVF_POS = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NBIT-1:0] sum_n,
  input  logic            ph_q,
  input  logic            ovf_q,
  output logic [NBIT-1:0] grp_a,
  output logic [NBIT-1:0] grp_b,
  output logic            evt_valid
);
  logic [NBIT-1:0] hold_n;
  logic            ph_d;
  logic            ovf_d;
  logic            a_fresh;
  logic            a_end;
  logic            b_end;
  logic [NBIT-1:0] a_next;

  assign a_end = ph_d && !ph_q;
  assign b_end = !ph_d && ph_q;

  always_comb begin
    a_next          = ~hold_n;
    a_next[OVF_POS] = ovf_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_n    <= '1;
      ph_d      <= 1'b0;
      ovf_d     <= 1'b0;
      grp_a     <= '0;
      grp_b     <= '0;
      a_fresh   <= 1'b0;
      evt_valid <= 1'b0;
    end else begin
      hold_n    <= sum_n;
      ph_d      <= ph_q;
      ovf_d     <= ovf_q;
      evt_valid <= b_end && a_fresh;
      if (a_end) begin
        grp_a   <= a_next;
        a_fresh <= 1'b1;
      end else if (b_end) begin
        a_fresh <= 1'b0;
      end
      if (b_end) grp_b <= ~hold_n;
    end
  end

  // R4: overflow flag lands in its slot on a group A update
  a_r4_ovf_slot: assert property (@(posedge clk) disable iff (rst)
    a_end |=> (grp_a[OVF_POS] == $past(ovf_d)));
  // R8: groups hold outside their own update cycle
  a_r8_hold_a: assert property (@(posedge clk) disable iff (rst)
    !$past(a_end) |-> $stable(grp_a));
  a_r8_hold_b: assert property (@(posedge clk) disable iff (rst)
    !$past(b_end) |-> $stable(grp_b));
  // R6: strobe lasts one cycle and follows a low-to-high phase edge
  a_r6_one_cycle: assert property (@(posedge clk) disable iff (rst)
    evt_valid |=> !evt_valid);
  a_r6_after_rise: assert property (@(posedge clk) disable iff (rst)
    evt_valid |-> ($past(ph_q) && !$past(ph_d)));
endmodule

// File: rtl/trig_pair_summary.sv
module trig_pair_summary
  import trig_pair_pkg::*;
#(
  parameter int unsigned NBUS    = BUS_COUNT_DEF,
  parameter int unsigned NBIT    = TRIG_BITS_DEF,
  parameter int unsigned OVF_POS = TRIG_BITS_DEF - 1
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  phase_in,
  input  logic                                  ovf_in,
  input  logic [pair_count(NBUS)*NBIT-1:0]      mom_res,
  input  logic [pair_count(NBUS)*NBIT-1:0]      ang_res,
  output logic [NBIT-1:0]                       sum_n,
  output logic [NBIT-1:0]                       grp_a,
  output logic [NBIT-1:0]                       grp_b,
  output logic                                  evt_valid
);
  localparam int unsigned NPAIR = pair_count(NBUS);

  logic ph_q;
  logic ovf_q;

  pair_combine #(.NPAIR(NPAIR), .NBIT(NBIT)) u_comb (
    .clk(clk), .rst(rst), .phase_in(phase_in), .ovf_in(ovf_in),
    .mom_res(mom_res), .ang_res(ang_res),
    .sum_n(sum_n), .ph_q(ph_q), .ovf_q(ovf_q)
  );

  phase_demux #(.NBIT(NBIT), .OVF_POS(OVF_POS)) u_demux (
    .clk(clk), .rst(rst), .sum_n(sum_n), .ph_q(ph_q), .ovf_q(ovf_q),
    .grp_a(grp_a), .grp_b(grp_b), .evt_valid(evt_valid)
  );

  // R7: reset leaves the outputs idle on the following cycle
  a_r7_reset_idle: assert property (@(posedge clk)
    rst |=> (sum_n == '1 && grp_a == '0 && grp_b == '0 && !evt_valid));
endmodule

// File: tb/sim_trig_pair_summary.sv
module sim_trig_pair_summary;
  localparam int NP = 15;
  localparam int NB = 8;
  localparam int W  = NP * NB;

  typedef struct packed {
    logic [3:0] hmp; logic [7:0] hmb; logic [3:0] hap; logic [7:0] hab;
    logic [3:0] lmp; logic [7:0] lmb; logic [3:0] lap; logic [7:0] lab;
    logic       ovf; logic [7:0] ea;  logic [7:0] eb;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{4'd0,  8'hFF, 4'd0,  8'h0F, 4'd14, 8'hF0, 4'd14, 8'h3C, 1'b0, 8'h0F, 8'h30},
    '{4'd3,  8'hFF, 4'd4,  8'hFF, 4'd7,  8'hAA, 4'd7,  8'hFF, 1'b1, 8'h80, 8'hAA},
    '{4'd9,  8'hFF, 4'd9,  8'hFF, 4'd2,  8'h81, 4'd2,  8'h01, 1'b0, 8'h7F, 8'h01},
    '{4'd14, 8'h80, 4'd14, 8'h80, 4'd0,  8'h80, 4'd0,  8'h80, 1'b0, 8'h00, 8'h80},
    '{4'd5,  8'h55, 4'd5,  8'hF0, 4'd11, 8'h00, 4'd11, 8'hFF, 1'b1, 8'hD0, 8'h00},
    '{4'd12, 8'hC3, 4'd12, 8'hFF, 4'd1,  8'hFF, 4'd1,  8'hFF, 1'b0, 8'h43, 8'hFF}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic phase_in = 1'b0;
  logic ovf_in = 1'b0;
  logic [W-1:0] mom_res = '0;
  logic [W-1:0] ang_res = '0;
  logic [NB-1:0] sum_n, grp_a, grp_b;
  logic evt_valid;

  int n_checks = 0;
  int n_fail = 0;
  logic [7:0] pend_b;
  logic       pend_ok = 1'b0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  trig_pair_summary u0 (
    .clk(clk), .rst(rst), .phase_in(phase_in), .ovf_in(ovf_in),
    .mom_res(mom_res), .ang_res(ang_res),
    .sum_n(sum_n), .grp_a(grp_a), .grp_b(grp_b), .evt_valid(evt_valid)
  );

  function automatic logic [7:0] model(input logic [W-1:0] m, input logic [W-1:0] a);
    logic [7:0] r = '0;
    for (int p = 0; p < NP; p++)
      for (int b = 0; b < NB; b++)
        if (m[p*NB+b] && a[p*NB+b]) r[b] = 1'b1;
    return r;
  endfunction

  function automatic logic [W-1:0] place(input logic [3:0] p, input logic [7:0] bits);
    logic [W-1:0] v = '0;
    v[p*NB +: NB] = bits;
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one event: high phase, then low phase; group B of the previous event is checked here
  task automatic run_event(input logic [W-1:0] hm, input logic [W-1:0] ha,
                           input logic [W-1:0] lm, input logic [W-1:0] la,
                           input logic ov, input logic [7:0] ea, input logic [7:0] eb);
    logic [7:0] hfull = model(hm, ha);
    logic [7:0] lfull = model(lm, la);
    phase_in = 1'b1; ovf_in = ov; mom_res = hm; ang_res = ha;
    tick(1);
    chk(sum_n == ~hfull, "R1/R2 high-phase summary", {8'h0, sum_n}, {8'h0, ~hfull});
    tick(1);
    if (pend_ok) begin
      chk(grp_b == pend_b, "R5 group B", {8'h0, grp_b}, {8'h0, pend_b});
      chk(evt_valid == 1'b1, "R6 strobe with group B", {15'h0, evt_valid}, 16'h1);
    end else begin
      chk(evt_valid == 1'b0, "R6 no strobe without group A", {15'h0, evt_valid}, 16'h0);
    end
    tick(1);
    chk(evt_valid == 1'b0, "R6 strobe one cycle", {15'h0, evt_valid}, 16'h0);
    tick(1);
    phase_in = 1'b0; ovf_in = 1'b0; mom_res = lm; ang_res = la;
    tick(1);
    chk(sum_n == ~lfull, "R2 low-phase summary", {8'h0, sum_n}, {8'h0, ~lfull});
    tick(1);
    chk(grp_a == ea, "R3/R4 group A", {8'h0, grp_a}, {8'h0, ea});
    tick(2);
    chk(grp_a == ea, "R8 group A held", {8'h0, grp_a}, {8'h0, ea});
    pend_b = eb; pend_ok = 1'b1;
  endtask

  initial begin
    tick(3);
    chk(sum_n == 8'hFF && grp_a == 8'h00 && grp_b == 8'h00 && !evt_valid,
        "R7 reset state", {sum_n, grp_a}, 16'hFF00);
    rst = 1'b0;
    tick(2);
    // table-driven events
    for (int v = 0; v < 6; v++) begin
      run_event(place(VECS[v].hmp, VECS[v].hmb), place(VECS[v].hap, VECS[v].hab),
                place(VECS[v].lmp, VECS[v].lmb), place(VECS[v].lap, VECS[v].lab),
                VECS[v].ovf, VECS[v].ea, VECS[v].eb);
    end
    // random events against the reference model
    for (int e = 0; e < 24; e++) begin
      logic [W-1:0] hm, ha, lm, la;
      logic [7:0] ea, eb;
      logic ov;
      hm = {$urandom, $urandom, $urandom, $urandom};
      ha = {$urandom, $urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom, $urandom};
      lm = {$urandom, $urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom, $urandom};
      la = {$urandom, $urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom, $urandom};
      if (e % 3 == 0) ha = ha & {$urandom, $urandom, $urandom, $urandom};
      ov = $urandom_range(0, 1);
      ea = model(hm, ha); ea[7] = ov;
      eb = model(lm, la);
      run_event(hm, ha, lm, la, ov, ea, eb);
    end
    // flush the last group B with an empty high phase
    phase_in = 1'b1; mom_res = '0; ang_res = '0;
    tick(2);
    chk(grp_b == pend_b, "R5 final group B", {8'h0, grp_b}, {8'h0, pend_b});
    chk(evt_valid == 1'b1, "R6 final strobe", {15'h0, evt_valid}, 16'h1);
    tick(2);
    chk(grp_b == pend_b, "R8 group B held", {8'h0, grp_b}, {8'h0, pend_b});
    // reset in mid-run clears the groups
    rst = 1'b1;
    tick(1);
    chk(sum_n == 8'hFF && grp_a == 8'h00 && grp_b == 8'h00 && !evt_valid,
        "R7 reset mid-run", {sum_n, grp_b}, 16'hFF00);
    rst = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule